// File: doc/BRIEF.md
# Level-Crossing Event Waveform Rebuilder

This block turns a stream of signed level-crossing events back into a sampled waveform. Every event says which way the input moved and how many output ticks have passed since the event before it. A running accumulator rises by one programmable amount on an upward event and falls by a second, independent amount on a downward event. Using two amounts lets the receiver correct a converter whose up and down thresholds are not symmetric.

Between events the accumulator holds its value, so the output is a zero-order-hold staircase. A fixed-rate tick, one every `TICK_DIV` clock cycles, emits one sample. Each event waits in a one-deep holding register until its interval runs out, and only then is it applied. Small errors in the step sizes add up over many events into a slow baseline wander. A one-pole high-pass stage runs on the tick stream and removes that wander, giving a second, drift-free output beside the raw staircase. A synchronous clear empties the accumulator, the filter and the held event together.

Top module: `dm_rebuild`

## Requirements
- R1: An event is taken on a clock edge where `ev_valid` and `ev_ready` are both high. `ev_ready` is high when no event is held, or when the held event is applied on that same edge. It is low whenever `clr` is high. `ev_pol` = 1 marks an upward event and 0 marks a downward event.
- R2: Applying an upward event adds `step_up`, read as an unsigned magnitude, to the signed accumulator.
- R3: Applying a downward event subtracts `step_dn`, read as an unsigned magnitude, from the accumulator.
- R4: An event taken on edge E is applied on tick number k + max(`ev_gap`, 1). Here k is the number of ticks up to and including E, so a gap of 0 acts like a gap of 1.
- R5: The accumulator saturates at +(2^(ACC_W-1) - 1) and -2^(ACC_W-1). It never wraps, and further events in the same direction leave it at the limit.
- R6: A tick occurs once every `TICK_DIV` cycles. On the cycle after each tick, `smp_valid` is high for exactly one cycle, and `smp_raw` shows the accumulator including any event applied on that tick.
- R7: A sample on which no event was applied carries the same `smp_raw` as the sample before it. Outside a tick or a clear, the outputs do not change.
- R8: On each tick, with x the new accumulator value and L the filter state (scaled by 2^HP_SHIFT), `smp_hp` = x - floor(L / 2^HP_SHIFT). After this, L becomes L + floor((x·2^HP_SHIFT - L) / 2^HP_SHIFT).
- R9: A cycle with `clr` high sets the accumulator, the filter state and both sample outputs to zero. It also drops any held event and drives `smp_valid` low on the next cycle.
- R10: After reset, `ev_ready` is 1, `smp_valid` is 0 and both sample outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of accumulator, filter and held event |
| step_up | input | STEP_W | Magnitude added by an upward event |
| step_dn | input | STEP_W | Magnitude subtracted by a downward event |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be taken this cycle |
| ev_pol | input | 1 | Event direction, 1 = up |
| ev_gap | input | GAP_W | Ticks from the previous event to this one |
| smp_valid | output | 1 | One-cycle strobe per output sample |
| smp_raw | output | ACC_W | Held accumulator value, signed |
| smp_hp | output | ACC_W+1 | High-passed sample, signed |

## Verification
The bench drives several kinds of event stream:
- Random direction, step and gap, with idle gaps between events, show whether application timing holds both when the bench presents events back to back and when it presents one after a pause.
- A deliberately lopsided pair of step sizes catches swapped or shared step magnitudes.
- Long runs in one direction at full step drive the accumulator into both rails, which separates saturation from wrapping.
- A single event with a long gap, and an event dropped by a clear while it waits, separate the hold behaviour from a held event that was wrongly applied.
- Long idle stretches after a burst let the high-pass output decay, which exposes any error in the filter's rounding or its shift.

// File: rtl/dm_rebuild.sv
module dm_rebuild #(
  parameter int ACC_W    = 24,
  parameter int STEP_W   = 16,
  parameter int GAP_W    = 8,
  parameter int TICK_DIV = 4,
  parameter int HP_SHIFT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic [STEP_W-1:0]        step_up,
  input  logic [STEP_W-1:0]        step_dn,
  input  logic                     ev_valid,
  output logic                     ev_ready,
  input  logic                     ev_pol,
  input  logic [GAP_W-1:0]         ev_gap,
  output logic                     smp_valid,
  output logic signed [ACC_W-1:0]  smp_raw,
  output logic signed [ACC_W:0]    smp_hp
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int SW    = ACC_W + 2;
  localparam int LW    = ACC_W + HP_SHIFT + 1;
  localparam logic signed [SW-1:0] HI = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [SW-1:0] LO = {3'b111, {(ACC_W-1){1'b0}}};

  logic [DIV_W-1:0]        tdiv;
  logic                    held, held_pol;
  logic [GAP_W-1:0]        left;
  logic signed [ACC_W-1:0] acc, acc_nx, acc_sat;
  logic signed [SW-1:0]    stepd, sum;
  logic signed [LW-1:0]    lp, xs, dlt;

  wire tick = (tdiv == DIV_W'(TICK_DIV - 1));
  wire due  = held && (left <= GAP_W'(1));
  wire fire = tick && due;
  wire take;

  assign ev_ready = !clr && (!held || fire);
  assign take     = ev_valid && ev_ready;

  assign stepd = held_pol ?  $signed({2'b00, {(ACC_W-STEP_W){1'b0}}, step_up})
                          : -$signed({2'b00, {(ACC_W-STEP_W){1'b0}}, step_dn});
  assign sum   = $signed({{2{acc[ACC_W-1]}}, acc}) + stepd;

  always_comb begin
    if (sum > HI)      acc_sat = HI[ACC_W-1:0];
    else if (sum < LO) acc_sat = LO[ACC_W-1:0];
    else               acc_sat = sum[ACC_W-1:0];
  end

  assign acc_nx = fire ? acc_sat : acc;
  assign xs     = $signed({{(HP_SHIFT+1){acc_nx[ACC_W-1]}}, acc_nx}) <<< HP_SHIFT;
  assign dlt    = xs - lp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tdiv      <= '0;
      held      <= 1'b0;
      held_pol  <= 1'b0;
      left      <= '0;
      acc       <= '0;
      lp        <= '0;
      smp_valid <= 1'b0;
      smp_raw   <= '0;
      smp_hp    <= '0;
    end else begin
      tdiv <= tick ? '0 : tdiv + DIV_W'(1);
      if (clr) begin
        held      <= 1'b0;
        acc       <= '0;
        lp        <= '0;
        smp_valid <= 1'b0;
        smp_raw   <= '0;
        smp_hp    <= '0;
      end else begin
        if (take) begin
          held     <= 1'b1;
          held_pol <= ev_pol;
          left     <= ev_gap;
        end else if (fire) begin
          held <= 1'b0;
        end else if (tick && held) begin
          left <= left - GAP_W'(1);
        end
        acc       <= acc_nx;
        smp_valid <= tick;
        if (tick) begin
          smp_raw <= acc_nx;
          smp_hp  <= (ACC_W+1)'($signed({{(HP_SHIFT+1){acc_nx[ACC_W-1]}}, acc_nx}) - (lp >>> HP_SHIFT));
          lp      <= lp + (dlt >>> HP_SHIFT);
        end
      end
    end
  end
endmodule

// File: rtl/dm_rebuild_chk.sv
module dm_rebuild_chk #(
  parameter int ACC_W    = 24,
  parameter int TICK_DIV = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clr,
  input logic                    ev_ready,
  input logic                    smp_valid,
  input logic signed [ACC_W-1:0] smp_raw,
  input logic signed [ACC_W:0]   smp_hp,
  input logic signed [ACC_W-1:0] acc,
  input logic                    fire,
  input logic                    held_pol
);
  localparam logic signed [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

  assert_ready_low_in_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !ev_ready);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && fire && held_pol && acc == MAXV) |=> acc == MAXV);

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && fire && !held_pol && acc == MINV) |=> acc == MINV);

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (TICK_DIV > 1 && smp_valid) |=> !smp_valid);

  assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (smp_valid || ($stable(smp_raw) && $stable(smp_hp))));

  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (smp_raw == '0 && smp_hp == '0 && !smp_valid));
endmodule

bind dm_rebuild dm_rebuild_chk #(.ACC_W(ACC_W), .TICK_DIV(TICK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .ev_ready(ev_ready),
  .smp_valid(smp_valid), .smp_raw(smp_raw), .smp_hp(smp_hp),
  .acc(acc), .fire(fire), .held_pol(held_pol)
);

// File: tb/test_dm_rebuild.sv
module test_dm_rebuild;
  localparam int ACC_W = 24, STEP_W = 16, GAP_W = 8, TICK_DIV = 4, HP_SHIFT = 8;
  localparam longint AMAX = (64'sd1 <<< (ACC_W-1)) - 1;
  localparam longint AMIN = -(64'sd1 <<< (ACC_W-1));

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, clr = 1'b0, ev_valid = 1'b0, ev_pol = 1'b0;
  logic [STEP_W-1:0] step_up = '0, step_dn = '0;
  logic [GAP_W-1:0]  ev_gap = '0;
  logic ev_ready, smp_valid;
  logic signed [ACC_W-1:0] smp_raw;
  logic signed [ACC_W:0]   smp_hp;

  dm_rebuild #(.ACC_W(ACC_W), .STEP_W(STEP_W), .GAP_W(GAP_W),
               .TICK_DIV(TICK_DIV), .HP_SHIFT(HP_SHIFT)) i_dm_rebuild (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step_up(step_up), .step_dn(step_dn),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_pol(ev_pol), .ev_gap(ev_gap),
    .smp_valid(smp_valid), .smp_raw(smp_raw), .smp_hp(smp_hp));

  int nchk = 0, nfail = 0;
  longint m_acc = 0, m_lp = 0;
  int t = 0;
  bit slot_v = 0, slot_pol = 0, ja_v = 0, ja_pol = 0;
  int slot_t = 0, ja_g = 0;

  task automatic check(string tag, longint act, longint exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint clamp(longint v);
    if (v > AMAX) return AMAX;
    if (v < AMIN) return AMIN;
    return v;
  endfunction

  // one clock: wait for the quiet half, score any sample, schedule any taken event
  task automatic run_cycle();
    string tg;
    longint y, d, raw;
    @(negedge clk);
    if (smp_valid) begin
      t++;
      tg = "R7";
      if (slot_v && slot_t == t) begin
        raw = slot_pol ? m_acc + longint'(step_up) : m_acc - longint'(step_dn);
        tg = slot_pol ? "R2" : "R3";
        if (raw != clamp(raw)) tg = "R5";
        m_acc = clamp(raw);
        slot_v = 0;
      end else if (slot_v && slot_t < t) begin
        tg = "R4";
      end
      check(tg, smp_raw, m_acc);
      d = (m_acc <<< HP_SHIFT) - m_lp;
      y = m_acc - (m_lp >>> HP_SHIFT);
      m_lp = m_lp + (d >>> HP_SHIFT);
      check("R8", smp_hp, y);
    end
    if (ja_v) begin
      slot_v = 1;
      slot_pol = ja_pol;
      slot_t = t + ((ja_g == 0) ? 1 : ja_g);
      ja_v = 0;
    end
  endtask

  task automatic drain(int c);
    ev_valid = 1'b0;
    repeat (c) run_cycle();
  endtask

  task automatic do_clear();
    clr = 1'b1;
    ev_valid = 1'b0;
    m_acc = 0; m_lp = 0; slot_v = 0; ja_v = 0;
    #1 check("R1", ev_ready, 0);
    run_cycle();
    clr = 1'b0;
    check("R9", smp_raw, 0);
    check("R9", smp_hp, 0);
    check("R9", smp_valid, 0);
  endtask

  // pmode: 0 down, 1 up, 2 random
  task automatic send(int n, int pmode, int gmin, int gmax, int idle_pct);
    bit hs;
    for (int i = 0; i < n; i++) begin
      if (int'($urandom % 100) < idle_pct) drain(1 + int'($urandom % 12));
      ev_pol   = (pmode == 2) ? 1'($urandom % 2) : 1'(pmode);
      ev_gap   = GAP_W'($urandom_range(gmax, gmin));
      ev_valid = 1'b1;
      hs = 0;
      while (!hs) begin
        #1;
        if (ev_valid && ev_ready) begin
          ja_v = 1; ja_pol = ev_pol; ja_g = int'(ev_gap); hs = 1;
        end
        run_cycle();
      end
    end
    ev_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R6 watchdog: got hung expected done");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R10", ev_ready, 1);
    check("R10", smp_valid, 0);
    check("R10", smp_raw, 0);
    check("R10", smp_hp, 0);
    rst_n = 1'b1;
    run_cycle();

    // lopsided steps, random traffic with pauses (R2, R3, R4)
    do_clear();
    step_up = 16'd7; step_dn = 16'd3;
    send(40, 2, 0, 4, 20);
    drain(40);

    // random magnitudes
    do_clear();
    step_up = STEP_W'($urandom); step_dn = STEP_W'($urandom);
    send(80, 2, 1, 6, 30);
    drain(30);

    // upper rail, then back down (R5)
    do_clear();
    step_up = 16'hFFFF; step_dn = 16'd1000;
    send(140, 1, 1, 1, 0);
    send(10, 0, 1, 1, 0);
    drain(10);

    // lower rail with zero gaps (R5, R4)
    do_clear();
    step_dn = 16'hFFFF;
    send(140, 0, 0, 0, 0);
    drain(10);

    // long gap, zero-order hold (R7, R4)
    do_clear();
    step_up = 16'd100;
    send(1, 1, 25, 25, 0);
    drain(150);

    // a held event is dropped by clear (R9)
    do_clear();
    send(1, 1, 20, 20, 0);
    drain(8);
    do_clear();
    drain(120);

    // burst then long idle: drift removal (R8)
    do_clear();
    step_up = 16'd500; step_dn = 16'd130;
    send(30, 1, 1, 1, 0);
    send(12, 0, 1, 2, 0);
    drain(1600);

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule